// File: doc/BRIEF.md
# Serial Flash Command Register Intake

This block is the front end of an octal-capable serial flash controller. Software stages a command across six 32-bit words on a simple register bus. It writes the five upper words first, and the write to the lowest word launches the command. The block decodes the staged words into a phase descriptor and hands that descriptor to a downstream phase engine over a valid/ready handshake. That descriptor carries the opcode, the address, the lane widths, the chip-select bank, and the optional data length, dummy clocks and direction.

An instruction word carries one of two kinds of instruction. The first is a command/address instruction, which may announce a data phase that comes later. The second is a data-sequence instruction. A command/address instruction that announces data is held in the block. It is released to the engine only when its data-sequence companion is launched, and the two are merged into one descriptor. The block also keeps the busy flag, a command status word, a work-mode field, and a write-one-to-clear interrupt status register gated by an enable mask.

Top module: `fcmd_frontend`

## Requirements
- R1: Command words 0..5 sit at byte offsets 0x00..0x14 and read back what was written. Only a write to offset 0x00 launches a command, and writes to words 1..5 never start one.
- R2: The instruction type is word 1 bits [6:0]. For type 0, a descriptor is offered with these fields: address byte 0 from word 1 [31:24], bytes 1..4 from word 2 lanes in ascending order, byte 5 from word 3 [7:0], opcode from word 3 [23:16], address byte count from word 3 [30:28], address lanes from word 4 [1:0], opcode lanes from word 4 [9:8], bank from word 4 [14:12], and the data flag clear.
- R3: A type 1 launch offers nothing and leaves busy clear. A later type 127 launch offers the held command/address fields merged with the data fields: the byte count is {word 3 [15:0], word 2 [31:16]}, dummy clocks come from word 3 [25:20], direction from word 4 bit 4 (1 means write), data lanes from word 4 [9:8], and the data flag is set.
- R4: An offered descriptor keeps valid asserted and its fields stable until ready is seen.
- R5: Busy (bit 7 at offset 0x100) is set from an accepted type 0 or type 127 launch until the engine reports done.
- R6: The command status at 0x44 is cleared by every accepted launch. When the engine reports done, the status becomes completed (bit 15), failed (bit 14) if any error cause is present, and the four causes in bits 3..0.
- R7: A launch is rejected if busy is set, if it is type 127 with nothing held, or if its type is not 0, 1 or 127. A rejected launch offers nothing and leaves 0xC001 in the command status.
- R8: Interrupt status at 0x110 latches command-done in bit 23, DMA error in bit 22 and DMA trigger in bit 21. Writing a one to a bit clears only that bit.
- R9: The interrupt output is high only when enable bit 31 at 0x114 is set and a pending status bit has its enable set in the same bit position.
- R10: For a data command, command-done is raised when the engine finishes if word 0 bit 0 was set at launch. If that bit was clear, command-done is raised when the descriptor is accepted. A type 0 command raises command-done when the engine finishes.
- R11: Config offset 0x230 stores a work mode in bits [6:5] (0 direct, 1 command-register, 3 auto-command), reads every other bit as zero, and drives the work_mode output.
- R12: Unmapped offsets read zero, and writes to offsets 0x44 and 0x100 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ph_valid | output | 1 | Descriptor offered |
| ph_ready | input | 1 | Engine accepts descriptor |
| ph_opcode | output | 8 | Opcode |
| ph_addr | output | 48 | Address, byte 0 in the low lane |
| ph_addr_bytes | output | 3 | Address byte count |
| ph_addr_lanes | output | 2 | Address lane width, log2 |
| ph_cmd_lanes | output | 2 | Opcode lane width, log2 |
| ph_bank | output | 3 | Chip-select bank |
| ph_has_data | output | 1 | Descriptor includes a data phase |
| ph_data_write | output | 1 | Data direction, 1 means write |
| ph_data_lanes | output | 2 | Data lane width, log2 |
| ph_byte_count | output | 32 | Data byte count |
| ph_dummy | output | 6 | Dummy clock count |
| eng_done | input | 1 | Engine finished the running command |
| eng_err | input | 4 | Error causes reported with eng_done |
| dma_err | input | 1 | DMA error event pulse |
| dma_trig | input | 1 | DMA trigger event pulse |
| irq | output | 1 | Interrupt request |
| work_mode | output | 2 | Work-mode field |

## Verification
The hardest cases to reach are the held-instruction path and the deferred completion. Each needs two launches in a set order, and the engine handshake must be paused between them. The stimulus first launches a type 1 instruction and checks that nothing is offered and that busy stays clear. It then launches the data-sequence companion, holds ready low while the merged fields are checked, and reads the command-done bit at two points: between acceptance and the engine done pulse, and after that pulse. This is done once with the defer bit set and once with it clear. A launch issued while a descriptor is still waiting for ready covers the reject-while-busy case.

// File: rtl/fcf_pkg.sv
package fcf_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 6;
  localparam int NUM_IRQ   = 3;
  localparam int IRQ_LO    = 21;
  localparam int IRQ_HI    = IRQ_LO + NUM_IRQ - 1;
  localparam int IRQ_GLOB  = 31;

  localparam int unsigned OFF_CMDSTAT = 32'h044;
  localparam int unsigned OFF_CTRLST  = 32'h100;
  localparam int unsigned OFF_IRQST   = 32'h110;
  localparam int unsigned OFF_IRQEN   = 32'h114;
  localparam int unsigned OFF_CFG     = 32'h230;

  localparam logic [6:0] TY_CA   = 7'd0;
  localparam logic [6:0] TY_CAD  = 7'd1;
  localparam logic [6:0] TY_DSEQ = 7'd127;

  typedef struct packed {
    logic [7:0]  opcode;
    logic [47:0] addr;
    logic [2:0]  addr_bytes;
    logic [1:0]  addr_lanes;
    logic [1:0]  cmd_lanes;
    logic [2:0]  bank;
  } ca_t;

  typedef struct packed {
    logic        wr;
    logic [1:0]  lanes;
    logic [31:0] count;
    logic [5:0]  dummy;
  } ds_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_OFFER, SQ_RUN} sq_state_e;
endpackage

// File: rtl/fcf_decode.sv
module fcf_decode
  import fcf_pkg::*;
(
  input  logic [WORD_W-1:0] w1,
  input  logic [WORD_W-1:0] w2,
  input  logic [WORD_W-1:0] w3,
  input  logic [WORD_W-1:0] w4,
  output logic [6:0]        ty,
  output ca_t               ca,
  output ds_t               ds
);
  logic unused_bits;
  assign unused_bits = ^{w1[23:7], w3[31], w3[27:26], w4[31:15], w4[11:10], w4[7:5], w4[3:2]};

  always_comb begin
    ty            = w1[6:0];
    ca.opcode     = w3[23:16];
    ca.addr       = {w3[7:0], w2[31:24], w2[23:16], w2[15:8], w2[7:0], w1[31:24]};
    ca.addr_bytes = w3[30:28];
    ca.addr_lanes = w4[1:0];
    ca.cmd_lanes  = w4[9:8];
    ca.bank       = w4[14:12];
    ds.wr         = w4[4];
    ds.lanes      = w4[9:8];
    ds.count      = {w3[15:0], w2[31:16]};
    ds.dummy      = w3[25:20];
  end
endmodule

// File: rtl/fcf_seq.sv
module fcf_seq
  import fcf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  logic       defer,
  input  logic [6:0] ty,
  input  ca_t        ca,
  input  ds_t        ds,
  input  logic       ph_ready,
  input  logic       eng_done,
  input  logic [3:0] eng_err,
  output logic       ph_valid,
  output ca_t        out_ca,
  output ds_t        out_ds,
  output logic       out_has_data,
  output logic       busy,
  output logic       st_done,
  output logic       st_fail,
  output logic [3:0] st_err,
  output logic       done_evt
);
  sq_state_e  state_q, state_d;
  logic       pend_q, pend_d;
  ca_t        pend_ca_q, pend_ca_d;
  ca_t        oca_q, oca_d;
  ds_t        ods_q, ods_d;
  logic       hasd_q, hasd_d, defer_q, defer_d;
  logic       done_q, done_d, fail_q, fail_d;
  logic [3:0] err_q, err_d;
  logic       idle, acc_ca, acc_cad, acc_ds, reject, finish;

  assign idle    = (state_q == SQ_IDLE);
  assign acc_ca  = launch && idle && (ty == TY_CA);
  assign acc_cad = launch && idle && (ty == TY_CAD);
  assign acc_ds  = launch && idle && (ty == TY_DSEQ) && pend_q;
  assign reject  = launch && !(acc_ca || acc_cad || acc_ds);
  assign finish  = (state_q == SQ_RUN) && eng_done;

  always_comb begin
    state_d   = state_q;
    pend_d    = pend_q;
    pend_ca_d = pend_ca_q;
    oca_d     = oca_q;
    ods_d     = ods_q;
    hasd_d    = hasd_q;
    defer_d   = defer_q;
    done_d    = done_q;
    fail_d    = fail_q;
    err_d     = err_q;
    case (state_q)
      SQ_IDLE: begin
        if (acc_ca) begin
          oca_d   = ca;
          ods_d   = '0;
          hasd_d  = 1'b0;
          defer_d = 1'b0;
          state_d = SQ_OFFER;
        end else if (acc_ds) begin
          oca_d   = pend_ca_q;
          ods_d   = ds;
          hasd_d  = 1'b1;
          defer_d = defer;
          pend_d  = 1'b0;
          state_d = SQ_OFFER;
        end else if (acc_cad) begin
          pend_d    = 1'b1;
          pend_ca_d = ca;
        end
      end
      SQ_OFFER: if (ph_ready) state_d = SQ_RUN;
      SQ_RUN:   if (eng_done) state_d = SQ_IDLE;
      default:  state_d = SQ_IDLE;
    endcase
    if (acc_ca || acc_cad || acc_ds) begin
      done_d = 1'b0;
      fail_d = 1'b0;
      err_d  = '0;
    end
    if (finish) begin
      done_d = 1'b1;
      fail_d = |eng_err;
      err_d  = eng_err;
    end
    if (reject) begin
      done_d = 1'b1;
      fail_d = 1'b1;
      err_d  = 4'b0001;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      pend_q    <= 1'b0;
      pend_ca_q <= '0;
      oca_q     <= '0;
      ods_q     <= '0;
      hasd_q    <= 1'b0;
      defer_q   <= 1'b0;
      done_q    <= 1'b0;
      fail_q    <= 1'b0;
      err_q     <= '0;
    end else begin
      state_q   <= state_d;
      pend_q    <= pend_d;
      pend_ca_q <= pend_ca_d;
      oca_q     <= oca_d;
      ods_q     <= ods_d;
      hasd_q    <= hasd_d;
      defer_q   <= defer_d;
      done_q    <= done_d;
      fail_q    <= fail_d;
      err_q     <= err_d;
    end
  end

  assign ph_valid     = (state_q == SQ_OFFER);
  assign busy         = !idle;
  assign out_ca       = oca_q;
  assign out_ds       = ods_q;
  assign out_has_data = hasd_q;
  assign st_done      = done_q;
  assign st_fail      = fail_q;
  assign st_err       = err_q;
  assign done_evt     = (finish && (!hasd_q || defer_q)) ||
                        ((state_q == SQ_OFFER) && ph_ready && hasd_q && !defer_q);
endmodule

// File: rtl/fcf_irq.sv
module fcf_irq
  import fcf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stat,
  input  logic               wr_en,
  input  logic [WORD_W-1:0]  wdata,
  input  logic [NUM_IRQ-1:0] set_src,
  output logic [NUM_IRQ-1:0] stat,
  output logic [NUM_IRQ-1:0] src_en,
  output logic               glob_en,
  output logic               irq
);
  logic [NUM_IRQ-1:0] stat_q, stat_d, en_q, en_d;
  logic               glob_q, glob_d;
  logic               unused_wbits;
  assign unused_wbits = ^{wdata[30:IRQ_HI+1], wdata[IRQ_LO-1:0]};

  always_comb begin
    stat_d = stat_q;
    en_d   = en_q;
    glob_d = glob_q;
    if (wr_stat) stat_d = stat_d & ~wdata[IRQ_HI:IRQ_LO];
    stat_d = stat_d | set_src;
    if (wr_en) begin
      en_d   = wdata[IRQ_HI:IRQ_LO];
      glob_d = wdata[IRQ_GLOB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      glob_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
      glob_q <= glob_d;
    end
  end

  assign stat    = stat_q;
  assign src_en  = en_q;
  assign glob_en = glob_q;
  assign irq     = glob_q && |(stat_q & en_q);
endmodule

// File: rtl/fcmd_frontend.sv
module fcmd_frontend
  import fcf_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              ph_valid,
  input  logic              ph_ready,
  output logic [7:0]        ph_opcode,
  output logic [47:0]       ph_addr,
  output logic [2:0]        ph_addr_bytes,
  output logic [1:0]        ph_addr_lanes,
  output logic [1:0]        ph_cmd_lanes,
  output logic [2:0]        ph_bank,
  output logic              ph_has_data,
  output logic              ph_data_write,
  output logic [1:0]        ph_data_lanes,
  output logic [31:0]       ph_byte_count,
  output logic [5:0]        ph_dummy,
  input  logic              eng_done,
  input  logic [3:0]        eng_err,
  input  logic              dma_err,
  input  logic              dma_trig,
  output logic              irq,
  output logic [1:0]        work_mode
);
  localparam logic [ADDR_W-1:0] A_CMDST = ADDR_W'(OFF_CMDSTAT);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRLST);
  localparam logic [ADDR_W-1:0] A_IRQST = ADDR_W'(OFF_IRQST);
  localparam logic [ADDR_W-1:0] A_IRQEN = ADDR_W'(OFF_IRQEN);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFF_CFG);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  // command word staging
  logic [WORD_W-1:0] words_q [NUM_WORDS];
  logic [WORD_W-1:0] words_d [NUM_WORDS];
  logic [NUM_WORDS-1:0] word_sel;

  for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
    assign word_sel[gi] = reg_we && (reg_addr == ADDR_W'(gi * 4));
    always_comb words_d[gi] = word_sel[gi] ? reg_wdata : words_q[gi];
    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n) words_q[gi] <= '0;
      else          words_q[gi] <= words_d[gi];
    end
  end

  // work-mode field
  logic [1:0] mode_q, mode_d;
  always_comb mode_d = (reg_we && reg_addr == A_CFG) ? reg_wdata[6:5] : mode_q;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) mode_q <= '0;
    else          mode_q <= mode_d;
  end
  assign work_mode = mode_q;

  // decode and sequencing
  logic [6:0] ty;
  ca_t        dec_ca, out_ca;
  ds_t        dec_ds, out_ds;
  logic       busy, st_done, st_fail, done_evt;
  logic [3:0] st_err;

  fcf_decode u_dec (
    .w1(words_q[1]), .w2(words_q[2]), .w3(words_q[3]), .w4(words_q[4]),
    .ty(ty), .ca(dec_ca), .ds(dec_ds)
  );

  fcf_seq u_seq (
    .clk(clk), .rst_n(rst_i_n),
    .launch(word_sel[0]), .defer(reg_wdata[0]),
    .ty(ty), .ca(dec_ca), .ds(dec_ds),
    .ph_ready(ph_ready), .eng_done(eng_done), .eng_err(eng_err),
    .ph_valid(ph_valid), .out_ca(out_ca), .out_ds(out_ds),
    .out_has_data(ph_has_data), .busy(busy),
    .st_done(st_done), .st_fail(st_fail), .st_err(st_err),
    .done_evt(done_evt)
  );

  assign ph_opcode     = out_ca.opcode;
  assign ph_addr       = out_ca.addr;
  assign ph_addr_bytes = out_ca.addr_bytes;
  assign ph_addr_lanes = out_ca.addr_lanes;
  assign ph_cmd_lanes  = out_ca.cmd_lanes;
  assign ph_bank       = out_ca.bank;
  assign ph_data_write = out_ds.wr;
  assign ph_data_lanes = out_ds.lanes;
  assign ph_byte_count = out_ds.count;
  assign ph_dummy      = out_ds.dummy;

  // interrupts: source order is {command-done, dma error, dma trigger}
  logic [NUM_IRQ-1:0] irq_stat, irq_src_en;
  logic               irq_glob_en;

  fcf_irq u_irq (
    .clk(clk), .rst_n(rst_i_n),
    .wr_stat(reg_we && reg_addr == A_IRQST),
    .wr_en(reg_we && reg_addr == A_IRQEN),
    .wdata(reg_wdata),
    .set_src({done_evt, dma_err, dma_trig}),
    .stat(irq_stat), .src_en(irq_src_en), .glob_en(irq_glob_en),
    .irq(irq)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (reg_addr == ADDR_W'(i * 4)) reg_rdata = words_q[i];
    end
    case (reg_addr)
      A_CMDST: reg_rdata = {16'b0, st_done, st_fail, 10'b0, st_err};
      A_CTRL:  reg_rdata = {24'b0, busy, 7'b0};
      A_IRQST: reg_rdata = {8'b0, irq_stat, 21'b0};
      A_IRQEN: reg_rdata = {irq_glob_en, 7'b0, irq_src_en, 21'b0};
      A_CFG:   reg_rdata = {25'b0, mode_q, 5'b0};
      default: ;
    endcase
  end
endmodule

// File: rtl/fcmd_frontend_chk.sv
module fcmd_frontend_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              ph_valid,
  input logic              ph_ready,
  input logic [7:0]        ph_opcode,
  input logic [47:0]       ph_addr,
  input logic [31:0]       ph_byte_count,
  input logic              busy,
  input logic              irq,
  input logic              glob_en
);
  a_r4_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_valid && !ph_ready) |=> ph_valid);

  a_r4_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_valid && !ph_ready) |=> ($stable(ph_opcode) && $stable(ph_addr) && $stable(ph_byte_count)));

  a_r5_busy_while_offer: assert property (@(posedge clk) disable iff (!rst_n)
    ph_valid |-> busy);

  a_r1_launch_word0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_valid) |-> $past(reg_we && reg_addr == '0));

  a_r9_irq_global: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> glob_en);
endmodule

bind fcmd_frontend fcmd_frontend_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .ph_valid(ph_valid), .ph_ready(ph_ready), .ph_opcode(ph_opcode),
  .ph_addr(ph_addr), .ph_byte_count(ph_byte_count), .busy(busy),
  .irq(irq), .glob_en(irq_glob_en)
);

// File: tb/fcmd_frontend_tb_top.sv
module fcmd_frontend_tb_top;
  localparam int AW = 12;
  localparam int NV = 4;

  // vector table: staged words and expected descriptor for type 0 commands
  localparam logic [31:0] TV_W1 [NV] = '{32'hA1000000, 32'h00000000, 32'hFF000000, 32'h12000000};
  localparam logic [31:0] TV_W2 [NV] = '{32'h55443322, 32'h00000000, 32'hFFFFFFFF, 32'h0000ABCD};
  localparam logic [31:0] TV_W3 [NV] = '{32'h509F0066, 32'h00060000, 32'h70FF00FF, 32'h30EB0000};
  localparam logic [31:0] TV_W4 [NV] = '{32'h00003102, 32'h00000000, 32'h00007303, 32'h00002201};
  localparam logic [7:0]  TV_OP [NV] = '{8'h9F, 8'h06, 8'hFF, 8'hEB};
  localparam logic [47:0] TV_AD [NV] = '{48'h6655443322A1, 48'h0, 48'hFFFFFFFFFFFF, 48'h000000ABCD12};
  localparam logic [2:0]  TV_NB [NV] = '{3'd5, 3'd0, 3'd7, 3'd3};
  localparam logic [2:0]  TV_BK [NV] = '{3'd3, 3'd0, 3'd7, 3'd2};
  localparam logic [3:0]  TV_LN [NV] = '{4'b0110, 4'b0000, 4'b1111, 4'b1001};

  logic          clk, rst_n, reg_we, ph_ready, eng_done, dma_err, dma_trig;
  logic [AW-1:0] reg_addr;
  logic [31:0]   reg_wdata, reg_rdata, ph_byte_count;
  logic [3:0]    eng_err;
  logic          ph_valid, ph_has_data, ph_data_write, irq;
  logic [7:0]    ph_opcode;
  logic [47:0]   ph_addr;
  logic [2:0]    ph_addr_bytes, ph_bank;
  logic [1:0]    ph_addr_lanes, ph_cmd_lanes, ph_data_lanes, work_mode;
  logic [5:0]    ph_dummy;

  int nchk = 0;
  int nbad = 0;
  bit finished = 0;

  fcmd_frontend #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ph_valid(ph_valid),
    .ph_ready(ph_ready), .ph_opcode(ph_opcode), .ph_addr(ph_addr),
    .ph_addr_bytes(ph_addr_bytes), .ph_addr_lanes(ph_addr_lanes),
    .ph_cmd_lanes(ph_cmd_lanes), .ph_bank(ph_bank), .ph_has_data(ph_has_data),
    .ph_data_write(ph_data_write), .ph_data_lanes(ph_data_lanes),
    .ph_byte_count(ph_byte_count), .ph_dummy(ph_dummy), .eng_done(eng_done),
    .eng_err(eng_err), .dma_err(dma_err), .dma_trig(dma_trig), .irq(irq),
    .work_mode(work_mode)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = '0;
  endtask

  task automatic stage(input logic [31:0] w1, input logic [31:0] w2,
                       input logic [31:0] w3, input logic [31:0] w4);
    wr(12'h014, 32'h0);
    wr(12'h010, w4);
    wr(12'h00C, w3);
    wr(12'h008, w2);
    wr(12'h004, w1);
  endtask

  task automatic accept();
    @(negedge clk); ph_ready = 1'b1;
    @(negedge clk); ph_ready = 1'b0;
  endtask

  task automatic finish_eng(input logic [3:0] e);
    @(negedge clk); eng_done = 1'b1; eng_err = e;
    @(negedge clk); eng_done = 1'b0; eng_err = '0;
  endtask

  initial begin
    #3000000;
    if (!finished) begin
      nchk++; nbad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    ph_ready = 1'b0; eng_done = 1'b0; eng_err = '0; dma_err = 1'b0; dma_trig = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    check("R5 reset busy", {63'b0, ph_valid}, 64'd0);
    rd(12'h100, r); check("R5 reset ctrl status", r, 64'h0);
    rd(12'h044, r); check("R6 reset cmd status", r, 64'h0);
    check("R9 reset irq", irq, 64'd0);

    // R1 staging without launch, readback
    stage(32'h00000000, 32'hDEADBEEF, 32'h00010000, 32'h0);
    repeat (2) @(negedge clk);
    check("R1 no launch from word1..5", ph_valid, 64'd0);
    rd(12'h008, r); check("R1 word2 readback", r, 64'hDEADBEEF);

    // vector loop: type 0 commands (R2, R4, R5, R6, R10)
    for (int v = 0; v < NV; v++) begin
      stage(TV_W1[v], TV_W2[v], TV_W3[v], TV_W4[v]);
      wr(12'h000, 32'h0);
      check("R2 valid", ph_valid, 64'd1);
      check("R2 opcode", ph_opcode, TV_OP[v]);
      check("R2 addr", ph_addr, TV_AD[v]);
      check("R2 addr bytes", ph_addr_bytes, TV_NB[v]);
      check("R2 bank", ph_bank, TV_BK[v]);
      check("R2 lanes", {ph_cmd_lanes, ph_addr_lanes}, TV_LN[v]);
      check("R2 no data", ph_has_data, 64'd0);
      rd(12'h044, r); check("R6 cleared at launch", r, 64'h0);
      @(negedge clk);
      check("R4 valid held", ph_valid, 64'd1);
      accept();
      check("R4 released", ph_valid, 64'd0);
      rd(12'h100, r); check("R5 busy running", r, 64'h80);
      finish_eng(4'b0000);
      rd(12'h100, r); check("R5 busy cleared", r, 64'h0);
      rd(12'h044, r); check("R6 completed", r, 64'h8000);
      rd(12'h110, r); check("R10 type0 done irq", r[23], 64'd1);
      wr(12'h110, 32'h00E00000);
    end

    // R3 held command/address then data-sequence, deferred done (R10)
    stage(32'h3C000001, 32'h0, 32'h10EC0000, 32'h00001000);
    wr(12'h000, 32'h0);
    repeat (2) @(negedge clk);
    check("R3 held not offered", ph_valid, 64'd0);
    rd(12'h100, r); check("R3 not busy while held", r, 64'h0);
    stage(32'h0000007F, 32'h23450000, 32'h00800001, 32'h00000310);
    wr(12'h000, 32'h1);
    check("R3 offered", ph_valid, 64'd1);
    check("R3 opcode", ph_opcode, 64'hEC);
    check("R3 addr", ph_addr, 64'h3C);
    check("R3 bank", ph_bank, 64'd1);
    check("R3 has data", ph_has_data, 64'd1);
    check("R3 count", ph_byte_count, 64'h00012345);
    check("R3 dummy", ph_dummy, 64'd8);
    check("R3 write dir", ph_data_write, 64'd1);
    check("R3 data lanes", ph_data_lanes, 64'd3);
    accept();
    rd(12'h110, r); check("R10 defer: no done before engine", r[23], 64'd0);
    finish_eng(4'b0000);
    rd(12'h110, r); check("R10 defer: done after engine", r[23], 64'd1);
    wr(12'h110, 32'h00E00000);

    // R10 no defer: done at acceptance
    stage(32'h01000001, 32'h0, 32'h00030000, 32'h0);
    wr(12'h000, 32'h0);
    stage(32'h0000007F, 32'h00100000, 32'h0, 32'h0);
    wr(12'h000, 32'h0);
    check("R3 read dir", ph_data_write, 64'd0);
    accept();
    rd(12'h110, r); check("R10 no defer: done at accept", r[23], 64'd1);
    finish_eng(4'b0000);
    wr(12'h110, 32'h00E00000);

    // R7 rejects
    stage(32'h0000007F, 32'h0, 32'h0, 32'h0);
    wr(12'h000, 32'h0);
    check("R7 dseq w/o held offered", ph_valid, 64'd0);
    rd(12'h044, r); check("R7 dseq w/o held status", r, 64'hC001);
    stage(32'h00000005, 32'h0, 32'h0, 32'h0);
    wr(12'h000, 32'h0);
    check("R7 bad type offered", ph_valid, 64'd0);
    rd(12'h044, r); check("R7 bad type status", r, 64'hC001);
    stage(32'h0, 32'h0, 32'h00AB0000, 32'h0);
    wr(12'h000, 32'h0);
    stage(32'h0, 32'h0, 32'h00CD0000, 32'h0);
    wr(12'h000, 32'h0);
    rd(12'h044, r); check("R7 busy reject status", r, 64'hC001);
    check("R7 busy reject keeps opcode", ph_opcode, 64'hAB);
    accept();
    finish_eng(4'b0101);
    rd(12'h044, r); check("R6 error causes", r, 64'hC005);
    wr(12'h110, 32'h00E00000);

    // R8 and R9 interrupts
    @(negedge clk); dma_err = 1'b1; dma_trig = 1'b1;
    @(negedge clk); dma_err = 1'b0; dma_trig = 1'b0;
    rd(12'h110, r); check("R8 dma bits set", r, 64'h00600000);
    check("R9 no irq when disabled", irq, 64'd0);
    wr(12'h114, 32'h80400000);
    check("R9 irq enabled", irq, 64'd1);
    wr(12'h114, 32'h00400000);
    check("R9 no irq without global", irq, 64'd0);
    wr(12'h114, 32'h80200000);
    wr(12'h110, 32'h00400000);
    rd(12'h110, r); check("R8 w1c clears only bit22", r, 64'h00200000);
    check("R9 irq from trigger", irq, 64'd1);
    wr(12'h110, 32'h00200000);
    check("R9 irq drops after clear", irq, 64'd0);
    rd(12'h114, r); check("R9 enable readback", r, 64'h80200000);

    // R11 config
    wr(12'h230, 32'hFFFFFFFF);
    rd(12'h230, r); check("R11 config readback", r, 64'h60);
    check("R11 work mode out", work_mode, 64'd3);
    wr(12'h230, 32'h00000020);
    check("R11 command mode", work_mode, 64'd1);

    // R12 unmapped and read-only
    rd(12'h200, r); check("R12 unmapped zero", r, 64'h0);
    wr(12'h044, 32'hFFFFFFFF);
    rd(12'h044, r); check("R12 cmd status unchanged", r, 64'hC005);
    wr(12'h100, 32'hFFFFFFFF);
    rd(12'h100, r); check("R12 ctrl status unchanged", r, 64'h0);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule